// File: doc/BRIEF.md
# DMA Interrupt Status Register

This block holds the interrupt status of a descriptor-driven Ethernet DMA engine. The transmit and receive DMA state machines send it single-cycle event pulses: frame sent, frame received, process halted, and descriptor owned by the host. Each pulse sets a sticky status bit. Software reads the 16-bit status word and clears chosen bits by writing ones to them.

A separate mask input selects which status bits raise the interrupt line. The same mask selects which of the three "abnormal" conditions feed a sticky summary bit. These conditions are transmit halted, receive halted and receive descriptor unavailable.

The block also contains a small receive-length watchdog. It counts the bytes of the frame being received and flags a frame that grows past a fixed limit. The receive-unavailable bit is edge-like: a run of host-owned descriptor fetches reports only once, at the first fetch that follows a DMA-owned one.

Top module: `dma_irq_status`

## Requirements
- R1: After synchronous reset, every status bit reads 0 and `irq` is low.
- R2: A pulse on `tx_done_evt`, `tx_stop_evt`, `tx_unavail_evt`, `rx_done_evt` or `rx_stop_evt` sets status bit 0, 1, 2, 6 or 8 respectively. The bit is visible after the clock edge that samples the pulse.
- R3: Status bits 14:10 and 5:3 always read 0, including after a write of ones to them.
- R4: A write with `clr_we` high clears every status bit whose `clr_data` bit is 1. Bits written with 0 keep their value.
- R5: When a set event and a clear write hit the same bit in the same cycle, the bit ends up set.
- R6: A receive descriptor fetch (`rx_fetch` high) with `rx_fetch_owned` low sets bit 7 only if the previous fetch was DMA-owned. Directly after reset, the previous fetch counts as DMA-owned. Consecutive host-owned fetches do not set bit 7 again, even after software has cleared it.
- R7: Bit 7 stays set until software clears it, however many cycles pass.
- R8: Bit 9 sets when the byte count of the current frame exceeds `WD_LIMIT` (default 2048). The count restarts at `rx_sof`; a byte valid in the same cycle as `rx_sof` counts as the first byte of the new frame. The bit sets at most once per frame.
- R9: Bit 15 sets one cycle after any of bits 1, 7 and 8 is set while its mask bit is 1. It is sticky, and it is cleared by writing 1 to bit 15. Sources whose mask bit is 0 do not set it.
- R10: `irq` is high exactly when some status bit is set and its `irq_mask` bit is 1. This holds for bit 15 as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_done_evt | input | 1 | Transmit frame completed pulse |
| tx_stop_evt | input | 1 | Transmit process entered stopped state |
| tx_unavail_evt | input | 1 | Next transmit descriptor is host-owned |
| rx_done_evt | input | 1 | Receive frame completed pulse |
| rx_stop_evt | input | 1 | Receive process entered stopped state |
| rx_fetch | input | 1 | Receive descriptor fetch completed |
| rx_fetch_owned | input | 1 | Fetched descriptor is DMA-owned (1) or host-owned (0) |
| rx_sof | input | 1 | Start of a received frame |
| rx_byte_vld | input | 1 | One received byte this cycle |
| clr_we | input | 1 | Software write-one-to-clear strobe |
| clr_data | input | 16 | Bits to clear |
| irq_mask | input | 16 | Per-bit interrupt and summary enable |
| status | output | 16 | Status word |
| irq | output | 1 | Interrupt request |

## Verification
Event-driven bits, including the watchdog and receive-unavailable bits, change at the first clock edge that samples the pulse. The summary bit follows one edge later, because it is set from the registered source bits. `irq` is combinational from the status word and the mask, so it moves in the same cycle as either of them.

The bench drives inputs just after a rising edge and queues the expected word once the capturing edge has passed. The monitor compares at the next falling edge. To catch the summary bit, the bench simply queues a second expectation one cycle later.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    localparam int SR_W = 16;

    localparam int B_TX_DONE  = 0;
    localparam int B_TX_STOP  = 1;
    localparam int B_TX_UNAV  = 2;
    localparam int B_RX_DONE  = 6;
    localparam int B_RX_UNAV  = 7;
    localparam int B_RX_STOP  = 8;
    localparam int B_RX_WDOG  = 9;
    localparam int B_ABN      = 15;

    localparam logic [SR_W-1:0] LIVE_BITS   = 16'h83C7;
    localparam logic [SR_W-1:0] ABN_SOURCES = 16'h0182;

    typedef struct packed {
        logic tx_done;
        logic tx_stop;
        logic tx_unav;
        logic rx_done;
        logic rx_unav;
        logic rx_stop;
        logic rx_wdog;
        logic abn;
    } irq_evt_t;

    function automatic logic [SR_W-1:0] evt_to_vec(input irq_evt_t e);
        logic [SR_W-1:0] v;
        v            = '0;
        v[B_TX_DONE] = e.tx_done;
        v[B_TX_STOP] = e.tx_stop;
        v[B_TX_UNAV] = e.tx_unav;
        v[B_RX_DONE] = e.rx_done;
        v[B_RX_UNAV] = e.rx_unav;
        v[B_RX_STOP] = e.rx_stop;
        v[B_RX_WDOG] = e.rx_wdog;
        v[B_ABN]     = e.abn;
        return v;
    endfunction

endpackage

// File: rtl/dma_irq_wdog.sv
module dma_irq_wdog #(
    parameter int LIMIT = 2048
) (
    input  logic clk,
    input  logic rst,
    input  logic sof,
    input  logic byte_vld,
    output logic trip
);
    localparam int CW = $clog2(LIMIT + 2);
    localparam logic [CW-1:0] AT_LIMIT = CW'(LIMIT);
    localparam logic [CW-1:0] SAT      = CW'(LIMIT + 1);

    logic [CW-1:0] cnt;

    // Fires only on the byte that moves the count past the limit.
    // The counter then saturates, so the trip cannot repeat within a frame.
    assign trip = byte_vld && !sof && (cnt == AT_LIMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (sof) begin
            cnt <= byte_vld ? CW'(1) : '0;
        end else if (byte_vld && cnt != SAT) begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/dma_irq_unavail.sv
module dma_irq_unavail (
    input  logic clk,
    input  logic rst,
    input  logic fetch,
    input  logic owned,
    output logic first_miss
);
    logic prev_owned;

    assign first_miss = fetch && !owned && prev_owned;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_owned <= 1'b1;
        end else if (fetch) begin
            prev_owned <= owned;
        end
    end
endmodule

// File: rtl/dma_irq_bits.sv
module dma_irq_bits
    import dma_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [SR_W-1:0] set_vec,
    input  logic            clr_we,
    input  logic [SR_W-1:0] clr_data,
    output logic [SR_W-1:0] q
);
    logic [SR_W-1:0] clr_vec;
    logic [SR_W-1:0] q_next;

    assign clr_vec = clr_we ? clr_data : '0;

    // A set in the same cycle as a clear wins.
    genvar i;
    generate
        for (i = 0; i < SR_W; i++) begin : g_bit
            if (LIVE_BITS[i]) begin : g_live
                assign q_next[i] = set_vec[i] | (q[i] & ~clr_vec[i]);
            end else begin : g_rsvd
                assign q_next[i] = 1'b0;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= q_next;
        end
    end
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
    import dma_irq_pkg::*;
#(
    parameter int WD_LIMIT = 2048
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tx_done_evt,
    input  logic        tx_stop_evt,
    input  logic        tx_unavail_evt,
    input  logic        rx_done_evt,
    input  logic        rx_stop_evt,
    input  logic        rx_fetch,
    input  logic        rx_fetch_owned,
    input  logic        rx_sof,
    input  logic        rx_byte_vld,
    input  logic        clr_we,
    input  logic [15:0] clr_data,
    input  logic [15:0] irq_mask,
    output logic [15:0] status,
    output logic        irq
);
    irq_evt_t        evt;
    logic [SR_W-1:0] set_vec;
    logic            wd_trip;
    logic            ru_first;

    dma_irq_wdog #(.LIMIT(WD_LIMIT)) u_wdog (
        .clk      (clk),
        .rst      (rst),
        .sof      (rx_sof),
        .byte_vld (rx_byte_vld),
        .trip     (wd_trip)
    );

    dma_irq_unavail u_unav (
        .clk        (clk),
        .rst        (rst),
        .fetch      (rx_fetch),
        .owned      (rx_fetch_owned),
        .first_miss (ru_first)
    );

    always_comb begin
        evt.tx_done = tx_done_evt;
        evt.tx_stop = tx_stop_evt;
        evt.tx_unav = tx_unavail_evt;
        evt.rx_done = rx_done_evt;
        evt.rx_unav = ru_first;
        evt.rx_stop = rx_stop_evt;
        evt.rx_wdog = wd_trip;
        evt.abn     = |(status & irq_mask & ABN_SOURCES);
    end

    assign set_vec = evt_to_vec(evt);

    dma_irq_bits u_bits (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (set_vec),
        .clr_we   (clr_we),
        .clr_data (clr_data),
        .q        (status)
    );

    assign irq = |(status & irq_mask);
endmodule

// File: rtl/dma_irq_status_chk.sv
module dma_irq_status_chk
    import dma_irq_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        tx_done_evt,
    input logic        rx_done_evt,
    input logic        rx_fetch,
    input logic        rx_fetch_owned,
    input logic        clr_we,
    input logic [15:0] clr_data,
    input logic [15:0] irq_mask,
    input logic [15:0] status,
    input logic        irq
);
    p_reserved_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (status & ~LIVE_BITS) == 16'h0);

    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
        tx_done_evt |=> status[B_TX_DONE]);

    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (clr_we && clr_data[B_RX_DONE] && !rx_done_evt) |=> !status[B_RX_DONE]);

    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (status[B_RX_UNAV] && !(clr_we && clr_data[B_RX_UNAV])) |=> status[B_RX_UNAV]);

    p_ru_once_r6: assert property (@(posedge clk) disable iff (rst)
        (rx_fetch && !rx_fetch_owned && !status[B_RX_UNAV]
         && $past(rx_fetch && !rx_fetch_owned)) |=> !status[B_RX_UNAV]);

    p_summary_r9: assert property (@(posedge clk) disable iff (rst)
        ((status & irq_mask & ABN_SOURCES) != 16'h0) |=> status[B_ABN]);

    p_irq_abn_r10: assert property (@(posedge clk) disable iff (rst)
        (status[B_ABN] && irq_mask[B_ABN]) |-> irq);
endmodule

bind dma_irq_status dma_irq_status_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .tx_done_evt    (tx_done_evt),
    .rx_done_evt    (rx_done_evt),
    .rx_fetch       (rx_fetch),
    .rx_fetch_owned (rx_fetch_owned),
    .clr_we         (clr_we),
    .clr_data       (clr_data),
    .irq_mask       (irq_mask),
    .status         (status),
    .irq            (irq)
);

// File: tb/dma_irq_status_tb.sv
`timescale 1ns/1ps
module dma_irq_status_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_done_evt = 0, tx_stop_evt = 0, tx_unavail_evt = 0;
    logic        rx_done_evt = 0, rx_stop_evt = 0;
    logic        rx_fetch = 0, rx_fetch_owned = 0;
    logic        rx_sof = 0, rx_byte_vld = 0;
    logic        clr_we = 0;
    logic [15:0] clr_data = '0;
    logic [15:0] irq_mask = '0;
    logic [15:0] status;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    typedef struct {
        string       tag;
        logic [15:0] st;
        logic        irq;
    } exp_t;

    exp_t exp_q[$];

    always #2 clk = ~clk;

    dma_irq_status u_dut (
        .clk(clk), .rst(rst),
        .tx_done_evt(tx_done_evt), .tx_stop_evt(tx_stop_evt),
        .tx_unavail_evt(tx_unavail_evt), .rx_done_evt(rx_done_evt),
        .rx_stop_evt(rx_stop_evt), .rx_fetch(rx_fetch),
        .rx_fetch_owned(rx_fetch_owned), .rx_sof(rx_sof),
        .rx_byte_vld(rx_byte_vld), .clr_we(clr_we), .clr_data(clr_data),
        .irq_mask(irq_mask), .status(status), .irq(irq)
    );

    // Monitor: compares queued expectations at the falling edge
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (status !== e.st || irq !== e.irq) begin
                n_fail++;
                $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                         e.tag, status, irq, e.st, e.irq);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_st(input string tag, input logic [15:0] st, input logic i);
        exp_t e;
        e.tag = tag; e.st = st; e.irq = i;
        exp_q.push_back(e);
        tick();
    endtask

    task automatic w1c(input logic [15:0] d);
        clr_we = 1; clr_data = d;
        tick();
        clr_we = 0; clr_data = '0;
    endtask

    task automatic fetch(input logic own);
        rx_fetch = 1; rx_fetch_owned = own;
        tick();
        rx_fetch = 0; rx_fetch_owned = 0;
    endtask

    task automatic bytes(input int n, input bit sof);
        for (int k = 0; k < n; k++) begin
            rx_byte_vld = 1;
            rx_sof = sof && (k == 0);
            tick();
        end
        rx_byte_vld = 0; rx_sof = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: status=%h irq=%b expected status=done irq=done", status, irq);
            summary();
        end
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        expect_st("R1 reset", 16'h0000, 1'b0);

        // R2 / R10
        tx_done_evt = 1; tick(); tx_done_evt = 0;
        expect_st("R2 tx_done", 16'h0001, 1'b0);
        irq_mask = 16'h0001; tick();
        expect_st("R10 mask on", 16'h0001, 1'b1);

        // R5 then R4
        tx_done_evt = 1; w1c(16'h0001); tx_done_evt = 0;
        expect_st("R5 set wins", 16'h0001, 1'b1);
        w1c(16'h0001);
        expect_st("R4 clear", 16'h0000, 1'b0);
        irq_mask = 16'h0000;

        // R2 remaining sources
        tx_stop_evt = 1; tick(); tx_stop_evt = 0;
        tx_unavail_evt = 1; tick(); tx_unavail_evt = 0;
        rx_done_evt = 1; tick(); rx_done_evt = 0;
        rx_stop_evt = 1; tick(); rx_stop_evt = 0;
        expect_st("R2 all sources", 16'h0146, 1'b0);
        w1c(16'h0040);
        expect_st("R4 partial clear", 16'h0106, 1'b0);
        w1c(16'hFFFF);
        expect_st("R3 reserved zero after ones", 16'h0000, 1'b0);

        // R9 summary
        irq_mask = 16'h0100;
        rx_stop_evt = 1; tick(); rx_stop_evt = 0;
        expect_st("R9 source first", 16'h0100, 1'b1);
        expect_st("R9 summary next", 16'h8100, 1'b1);
        w1c(16'h0100);
        expect_st("R9 summary sticky", 16'h8000, 1'b0);
        irq_mask = 16'h8000; tick();
        expect_st("R10 summary irq", 16'h8000, 1'b1);
        w1c(16'h8000);
        expect_st("R9 summary clear", 16'h0000, 1'b0);
        irq_mask = 16'h0000;
        tx_stop_evt = 1; tick(); tx_stop_evt = 0;
        tick(); tick();
        expect_st("R9 masked source", 16'h0002, 1'b0);
        w1c(16'h0002);

        // R6 / R7
        fetch(1'b0);
        expect_st("R6 first miss after reset", 16'h0080, 1'b0);
        w1c(16'h0080);
        fetch(1'b0);
        expect_st("R6 repeat miss", 16'h0000, 1'b0);
        fetch(1'b1);
        expect_st("R6 owned fetch", 16'h0000, 1'b0);
        fetch(1'b0);
        repeat (5) tick();
        expect_st("R7 sticky", 16'h0080, 1'b0);
        w1c(16'h0080);

        // R8 watchdog
        bytes(2000, 1);
        bytes(2000, 1);
        expect_st("R8 restart on sof", 16'h0000, 1'b0);
        bytes(48, 0);
        expect_st("R8 at limit", 16'h0000, 1'b0);
        bytes(1, 0);
        expect_st("R8 over limit", 16'h0200, 1'b0);
        w1c(16'h0200);
        bytes(100, 0);
        expect_st("R8 once per frame", 16'h0000, 1'b0);
        bytes(2049, 1);
        expect_st("R8 new frame", 16'h0200, 1'b0);

        tick(); tick();
        finished = 1;
        summary();
    end
endmodule